// File: doc/BRIEF.md
# Converter Conversion Control and Status

This block is the digital sequencing logic that sits beside a successive-approximation converter. Software drives it through one 8-bit control/status register that holds an enable, a start bit, an auto-trigger enable, a completion flag, a flag-interrupt enable and a 3-bit prescaler select. A converter clock is derived from the system clock by the selected power-of-two divider, and the block counts converter clock ticks to time each conversion. When a conversion ends, the 10-bit result presented on `res_in` is latched into a low and a high data register, the flag is raised and, if allowed, an interrupt request goes out.

A conversion begins on a software write of the start bit, on a rising edge of the selected trigger line when auto-triggering is on, or automatically at the end of the previous conversion when auto-triggering is on and the free-running source is selected on `free_run`. The first conversion after enabling runs a longer initialization sequence; later ones are short. Clearing the enable stops the converter clock and throws away any conversion in flight.

Top module: `adc_ctrl_status`

## Requirements
- R1: After reset every register bit reads 0, the data registers read 0 and `irq` is 0. Register layout: bit 7 enable, bit 6 start/busy, bit 5 auto-trigger enable, bit 4 flag, bit 3 interrupt enable, bits 2:0 prescaler select.
- R2: A write with bit 7 = 0 during a conversion aborts it at once: bit 6 reads 0, no result is latched and the flag stays 0.
- R3: With bit 5 = 0 a completed conversion leaves bit 6 at 0; with bit 5 = 1 and `free_run` = 1, one software start is followed by back-to-back conversions, bit 6 staying 1 and the flag being set at every completion.
- R4: The first conversion started after the enable goes from 0 to 1 (including a start written in the same write that sets the enable) lasts 25 converter clock periods; every later one lasts 13.
- R5: Bit 6 reads 1 from the clock edge that starts a conversion until the edge that completes it; writing 0 to bit 6 has no effect on a running conversion.
- R6: With bit 7 = 1, bit 5 = 1 and `free_run` = 0, a 0-to-1 transition of `trig_in` starts a conversion on the next clock edge; with bit 5 = 0 the trigger line is ignored, and a level held high starts nothing further.
- R7: At the completion edge the flag sets and `res_in` is latched; the data registers then hold until the next completion.
- R8: The flag clears on a write with bit 4 = 1 (writing 0 leaves it) or on an `irq_ack` pulse; a completion in the same cycle as a clear wins and leaves the flag at 1.
- R9: `irq` is 1 exactly when the flag, bit 3 and `gie` are all 1.
- R10: Prescaler codes 0..7 divide the system clock by 2, 2, 4, 8, 16, 32, 64, 128, and the converter clock restarts its phase on each conversion start, so a conversion of N periods takes N times the divide factor system clocks.
- R11: A software start or trigger edge that arrives while a conversion is running is ignored; the running conversion ends at its original time.
- R12: `data_lo` carries result bits 7:0; `data_hi` carries result bits 9:8 in its bits 1:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| csr_rdata | output | 8 | Register read value, bit 6 showing busy |
| trig_in | input | 1 | Selected auto-trigger line |
| free_run | input | 1 | Selects free-running restart as the auto-trigger source |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| res_in | input | 10 | Conversion result from the converter |
| data_lo | output | 8 | Result bits 7:0 |
| data_hi | output | 8 | Result bits 9:8, zero-extended |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench measures conversion lengths to the exact cycle under two dividers, so a design that forgot the long first run, re-armed it wrongly after an abort, or let the divider phase drift would finish one or more cycles early or late. It aborts mid-conversion and confirms no result or flag appears, which catches a design that lets a stale tick complete. It writes a second start and a zero start bit into a busy conversion and raises a trigger edge during one, so a design that restarts on these would finish late. It lands an acknowledge on the completion edge, where a design giving the clear priority would lose the flag.

// File: rtl/adc_pkg.sv
package adc_pkg;

    localparam int CSR_W     = 8;
    localparam int PS_W      = 3;
    localparam int PRE_W     = 7;
    localparam int EN_BIT    = 7;
    localparam int START_BIT = 6;
    localparam int ATE_BIT   = 5;
    localparam int FLAG_BIT  = 4;
    localparam int IE_BIT    = 3;

    // Software-written control fields (start and flag are kept elsewhere)
    typedef struct packed {
        logic            en;
        logic            ate;
        logic            ie;
        logic [PS_W-1:0] ps;
    } ctl_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_INIT = 2'd1,
        SQ_NORM = 2'd2
    } seq_state_e;

    // Low-bit mask of the divider counter: divide factor minus one
    function automatic logic [PRE_W-1:0] ps_mask(input logic [PS_W-1:0] code);
        int sh;
        sh = (code == '0) ? 1 : int'(code);
        return PRE_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_pkg::*;
#(
    parameter int CNT_W = PRE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            clear,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    always_comb mask = CNT_W'(ps_mask(ps));

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign tick = run && ((cnt & mask) == mask);

    // Divide factor is at least two, so ticks never come back to back
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R10

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adc_pkg::*;
#(
    parameter int INIT_LEN = 25,
    parameter int NORM_LEN = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic tick,
    input  logic go,
    input  logic again,
    output logic busy,
    output logic done,
    output logic launch
);

    localparam int CW = $clog2(INIT_LEN + 1);

    seq_state_e    state;
    logic          armed;
    logic [CW-1:0] cnt;
    logic          last;

    assign busy = (state != SQ_IDLE);

    always_comb begin
        if (state == SQ_INIT) last = (cnt == CW'(INIT_LEN - 1));
        else                  last = (cnt == CW'(NORM_LEN - 1));
    end

    assign done   = busy && tick && last && !kill;
    assign launch = !kill && ((!busy && go) || (done && again));

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            state <= SQ_IDLE;
            armed <= 1'b0;
            cnt   <= '0;
        end else if (launch) begin
            state <= armed ? SQ_NORM : SQ_INIT;
            armed <= 1'b1;
            cnt   <= '0;
        end else if (done) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else if (busy && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_KILL_STOPS: assert property (@(posedge clk) disable iff (rst)
        kill |=> !busy); // R2

    AST_FIRST_IS_LONG: assert property (@(posedge clk) disable iff (rst)
        (launch && !busy && !armed) |=> (state == SQ_INIT)); // R4

endmodule

// File: rtl/adc_csr.sv
module adc_csr
    import adc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             busy,
    input  logic             done,
    input  logic             irq_ack,
    input  logic             gie,
    output ctl_t             ctl,
    output logic [CSR_W-1:0] rdata,
    output logic             irq
);

    logic flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl.en  <= wr_data[EN_BIT];
            ctl.ate <= wr_data[ATE_BIT];
            ctl.ie  <= wr_data[IE_BIT];
            ctl.ps  <= wr_data[PS_W-1:0];
        end
    end

    // Completion has priority over both clear sources
    always_ff @(posedge clk) begin
        if (rst)                                     flag <= 1'b0;
        else if (done)                               flag <= 1'b1;
        else if ((wr_en && wr_data[FLAG_BIT]) || irq_ack) flag <= 1'b0;
    end

    assign rdata = {ctl.en, busy, ctl.ate, flag, ctl.ie, ctl.ps};
    assign irq   = flag && ctl.ie && gie;

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> rdata[FLAG_BIT]); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !done) |=> !rdata[FLAG_BIT]); // R8

endmodule

// File: rtl/adc_ctrl_status.sv
module adc_ctrl_status
    import adc_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int INIT_LEN = 25,
    parameter int NORM_LEN = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             trig_in,
    input  logic             free_run,
    input  logic             gie,
    input  logic             irq_ack,
    input  logic [RES_W-1:0] res_in,
    output logic [7:0]       data_lo,
    output logic [7:0]       data_hi,
    output logic             irq
);

    localparam int HI_W = RES_W - 8;

    ctl_t             ctl;
    logic             trig_q;
    logic             trig_edge;
    logic             kill, sw_go, hw_go, go, again;
    logic             tick, busy, done, launch;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign trig_edge = trig_in && !trig_q;
    assign kill      = wr_en && !wr_data[EN_BIT];
    assign sw_go     = wr_en && wr_data[EN_BIT] && wr_data[START_BIT];
    assign hw_go     = ctl.en && ctl.ate && !free_run && trig_edge;
    assign go        = sw_go || hw_go;
    assign again     = ctl.en && ctl.ate && free_run;

    adc_prescaler #(.CNT_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (ctl.en),
        .clear (launch),
        .ps    (ctl.ps),
        .tick  (tick)
    );

    adc_sequencer #(.INIT_LEN(INIT_LEN), .NORM_LEN(NORM_LEN)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .kill   (kill),
        .tick   (tick),
        .go     (go),
        .again  (again),
        .busy   (busy),
        .done   (done),
        .launch (launch)
    );

    adc_csr u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy),
        .done    (done),
        .irq_ack (irq_ack),
        .gie     (gie),
        .ctl     (ctl),
        .rdata   (csr_rdata),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)       res_q <= '0;
        else if (done) res_q <= res_in;
    end

    assign data_lo = res_q[7:0];
    assign data_hi = 8'(res_q[RES_W-1:8]);

    AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[START_BIT] |-> csr_rdata[EN_BIT]); // R2

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(res_q)); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (sw_go && busy && !done) |=> busy); // R11

    initial begin
        assert (HI_W >= 1 && HI_W <= 8); // R12
    end

endmodule

// File: tb/tb_adc_ctrl_status.sv
module tb_adc_ctrl_status;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] csr_rdata;
    logic       trig_in = 1'b0;
    logic       free_run = 1'b0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic [9:0] res_in = '0;
    logic [7:0] data_lo, data_hi;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_ctrl_status dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .csr_rdata (csr_rdata),
        .trig_in   (trig_in),
        .free_run  (free_run),
        .gie       (gie),
        .irq_ack   (irq_ack),
        .res_in    (res_in),
        .data_lo   (data_lo),
        .data_hi   (data_hi),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 csr after reset", 32'(csr_rdata), 32'h00);
        chk("R1 data_lo after reset", 32'(data_lo), 32'h00);
        chk("R1 data_hi after reset", 32'(data_hi), 32'h00);
        chk("R1 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_first_long;
        res_in = 10'h2A5;
        wr(8'hC0);
        chk("R5 busy reads 1 after start", 32'(csr_rdata[6]), 32'h1);
        waitn(49);
        chk("R4 first conv still busy at 49", 32'(csr_rdata[6]), 32'h1);
        chk("R7 no flag before completion", 32'(csr_rdata[4]), 32'h0);
        waitn(1);
        chk("R4 R10 first conv done at 50", 32'(csr_rdata), 32'h90);
        chk("R12 data_lo", 32'(data_lo), 32'hA5);
        chk("R12 data_hi", 32'(data_hi), 32'h02);
        res_in = 10'h0F0;
        waitn(5);
        chk("R7 data holds", 32'(data_lo), 32'hA5);
    endtask

    task automatic t_second_short;
        wr(8'h90);
        chk("R8 W1C clears flag", 32'(csr_rdata), 32'h80);
        res_in = 10'h15C;
        wr(8'hC3);
        waitn(103);
        chk("R4 R10 short conv busy at 103", 32'(csr_rdata[6]), 32'h1);
        waitn(1);
        chk("R3 single mode idle after done", 32'(csr_rdata), 32'h93);
        chk("R12 data_lo second", 32'(data_lo), 32'h5C);
        chk("R12 data_hi second", 32'(data_hi), 32'h01);
    endtask

    task automatic t_busy_ignore;
        wr(8'h91);
        wr(8'hC1);
        waitn(5);
        wr(8'h81);
        chk("R5 zero start keeps busy", 32'(csr_rdata[6]), 32'h1);
        wr(8'hC1);
        waitn(18);
        chk("R11 still busy at 25", 32'(csr_rdata[6]), 32'h1);
        waitn(1);
        chk("R11 ends at original time", 32'(csr_rdata), 32'h91);
    endtask

    task automatic t_abort;
        logic [7:0] lo_before;
        wr(8'h91);
        lo_before = data_lo;
        res_in = 10'h3FF;
        wr(8'hC1);
        waitn(10);
        wr(8'h01);
        chk("R2 abort idles", 32'(csr_rdata), 32'h01);
        waitn(40);
        chk("R2 no flag after abort", 32'(csr_rdata[4]), 32'h0);
        chk("R2 no data after abort", 32'(data_lo), 32'(lo_before));
        wr(8'hC1);
        waitn(49);
        chk("R4 long again after re-enable", 32'(csr_rdata[6]), 32'h1);
        waitn(1);
        chk("R4 re-enable conv done at 50", 32'(csr_rdata), 32'h91);
        chk("R7 data after re-enable", 32'(data_lo), 32'hFF);
    endtask

    task automatic t_irq;
        wr(8'h89);
        gie = 1'b0;
        #1;
        chk("R9 irq gated by gie", 32'(irq), 32'h0);
        gie = 1'b1;
        #1;
        chk("R9 irq asserted", 32'(irq), 32'h1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R8 ack clears flag", 32'(csr_rdata[4]), 32'h0);
        chk("R9 irq drops", 32'(irq), 32'h0);
        wr(8'hC9);
        waitn(25);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R8 set wins over ack", 32'(csr_rdata), 32'h99);
        wr(8'h81);
        chk("R9 irq off with ie 0", 32'(irq), 32'h0);
        gie = 1'b0;
    endtask

    task automatic t_trigger;
        free_run = 1'b0;
        wr(8'hB1);
        trig_in = 1'b1;
        @(negedge clk);
        chk("R6 trigger edge starts", 32'(csr_rdata[6]), 32'h1);
        waitn(5);
        trig_in = 1'b0;
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        waitn(18);
        chk("R11 trigger during busy ignored", 32'(csr_rdata[6]), 32'h1);
        waitn(1);
        chk("R6 trigger conv done", 32'(csr_rdata), 32'hB1);
        waitn(4);
        chk("R6 held level no restart", 32'(csr_rdata[6]), 32'h0);
        trig_in = 1'b0;
        wr(8'h91);
        trig_in = 1'b1;
        waitn(3);
        chk("R6 trigger ignored when ate 0", 32'(csr_rdata[6]), 32'h0);
        trig_in = 1'b0;
    endtask

    task automatic t_free_run;
        free_run = 1'b1;
        wr(8'hB1);
        res_in = 10'h1C3;
        wr(8'hF1);
        waitn(26);
        chk("R3 free run keeps busy", 32'(csr_rdata), 32'hF1);
        chk("R7 free run first data", 32'(data_lo), 32'hC3);
        res_in = 10'h234;
        wr(8'hB1);
        waitn(24);
        chk("R3 flag clear between runs", 32'(csr_rdata[4]), 32'h0);
        waitn(1);
        chk("R3 second auto conv flag", 32'(csr_rdata), 32'hF1);
        chk("R12 free run data_hi", 32'(data_hi), 32'h02);
        wr(8'h01);
        chk("R2 free run abort", 32'(csr_rdata[6]), 32'h0);
        free_run = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_long();
        t_second_short();
        t_busy_ignore();
        t_abort();
        t_irq();
        t_trigger();
        t_free_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule